// File: doc/BRIEF.md
# Compact HDR Color Packer

This block turns a linear high-dynamic-range pixel into one 32-bit render-target word and turns such words back into linear values. Each of the three color channels arrives as an unsigned 16.16 fixed-point number. It is stored as a 10-bit unsigned small float with a 3-bit exponent and a 7-bit mantissa, which covers the range from 0 up to just under 16. An 8-bit alpha is reduced to a 2-bit code. The four fields fill the 32-bit word exactly.

The packer is a three-stage pipeline: leading-one detect, then shift and round, then pack. A valid strobe travels alongside the data and there is no stall path, so a new pixel can enter on every cycle. A separate unpack port takes a packed word and gives back the three fixed-point channels and an 8-bit alpha one cycle later. This is useful for readback and for round-trip checks. Blending and multisample resolve are done elsewhere.

Top module: `hdr_pack_top`

## Requirements
- R1: The packed word holds red in bits [31:22], green in [21:12], blue in [11:2] and the alpha code in [1:0].
- R2: A channel code {e[9:7], m[6:0]} with e greater than 0 stands for (1 + m/128) * 2^(e-4). An input at or above 0.125 (16.16 value 0x2000) is encoded with the exponent chosen so that the leading one becomes the hidden bit.
- R3: Code exponent 0 is denormal and stands for m/1024. Inputs below 0x1FE0 get exponent 0, with m equal to the input divided by 64 and rounded.
- R4: Dropped mantissa bits are rounded to nearest, with ties going to the even mantissa. A round-up that overflows the mantissa carries into the exponent, so 0x1FE0 encodes as 0x080.
- R5: Any channel input of 0x000FF000 (15.9375) or more encodes as 0x3FF.
- R6: The alpha code is (a*3 + 127) / 255 using integer division, which gives 0 for a below 43, 1 up to 127, 2 up to 212, and 3 above that.
- R7: outWord and outValid appear exactly three cycles after the inValid cycle that carried the pixel. Back-to-back pixels are accepted every cycle, and outValid is low in every other cycle.
- R8: One cycle after unpkValid, unpkOutValid is high and each channel equals its code's exact value in 16.16: m*64 for exponent 0, otherwise (128+m) << (e+5). unpkAlpha equals the 2-bit code times 85.
- R9: While rstN is low, both valid outputs are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Pixel present on the pack inputs |
| inRed | input | 32 | Red channel, unsigned 16.16 |
| inGreen | input | 32 | Green channel, unsigned 16.16 |
| inBlue | input | 32 | Blue channel, unsigned 16.16 |
| inAlpha | input | 8 | Alpha, 0 to 255 |
| outValid | output | 1 | Packed word present |
| outWord | output | 32 | Packed render-target word |
| unpkValid | input | 1 | Word present on the unpack input |
| unpkWord | input | 32 | Packed word to expand |
| unpkOutValid | output | 1 | Unpacked pixel present |
| unpkRed | output | 32 | Expanded red, 16.16 |
| unpkGreen | output | 32 | Expanded green, 16.16 |
| unpkBlue | output | 32 | Expanded blue, 16.16 |
| unpkAlpha | output | 8 | Expanded alpha |

## Verification
Directed pixels target specific cases:
- Exact ties in the denormal range and in the normal range separate round-to-nearest-even from plain half-up rounding.
- The value just under 0.125 shows whether the mantissa carry moves into the exponent.
- Values at the saturation limit and just under it separate clamping from rounding.
- Alpha values on each side of every code threshold pin down the 8-to-2 reduction.
- Distinct values per channel expose swapped fields.

Random magnitudes spread over every exponent, mixed with idle cycles, test the pipeline timing. Random words fed to the unpack port check the exact expansion of every code class.

// File: rtl/hdr_pack_pkg.sv
package hdr_pack_pkg;
  localparam int FIX_W      = 32;
  localparam int FRAC_W     = 16;
  localparam int EXP_W      = 3;
  localparam int MAN_W      = 7;
  localparam int EXP_BIAS   = 4;
  localparam int NUM_CH     = 3;
  localparam int ALPHA_IN_W = 8;
  localparam int ALPHA_W    = 2;
  localparam int PIPE_DEPTH = 3;

  localparam int CODE_W    = EXP_W + MAN_W;
  localparam int WORD_W    = NUM_CH * CODE_W + ALPHA_W;
  localparam int EXP_MAX   = (1 << EXP_W) - 1;
  localparam int LEAD_OFS  = FRAC_W - EXP_BIAS;
  localparam int TOP_BIT   = EXP_MAX + LEAD_OFS;
  localparam int DEN_SHIFT = LEAD_OFS + 1 - MAN_W;
  localparam int SAT_LIMIT = ((1 << (MAN_W + 1)) - 1) << (EXP_MAX + LEAD_OFS - MAN_W);
  localparam int A_MAX     = (1 << ALPHA_W) - 1;
  localparam int AIN_MAX   = (1 << ALPHA_IN_W) - 1;
  localparam int A_REP     = ALPHA_IN_W / ALPHA_W;

  typedef logic [FIX_W-1:0]  fix_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [EXP_W-1:0]  exp_t;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ldUnpk;
  } strobe_t;
endpackage

// File: rtl/hdr_pack_ctrl.sv
module hdr_pack_ctrl
  import hdr_pack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    unpkValid,
  output strobe_t stb,
  output logic    outValid,
  output logic    unpkOutValid
);
  logic [PIPE_DEPTH-1:0] vPipe;
  logic                  unpkV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe <= '0;
      unpkV <= 1'b0;
    end else begin
      vPipe <= {vPipe[PIPE_DEPTH-2:0], inValid};
      unpkV <= unpkValid;
    end
  end

  always_comb begin
    stb.ld1    = inValid;
    stb.ld2    = vPipe[0];
    stb.ld3    = vPipe[1];
    stb.ldUnpk = unpkValid;
  end

  assign outValid     = vPipe[PIPE_DEPTH-1];
  assign unpkOutValid = unpkV;
endmodule

// File: rtl/hdr_pack_dp.sv
module hdr_pack_dp
  import hdr_pack_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [NUM_CH-1:0][FIX_W-1:0]   inCh,
  input  logic [ALPHA_IN_W-1:0]          inAlpha,
  input  logic [WORD_W-1:0]              unpkWord,
  output logic [WORD_W-1:0]              packWord,
  output logic [NUM_CH-1:0][FIX_W-1:0]   unpkCh,
  output logic [ALPHA_IN_W-1:0]          unpkAlpha
);
  logic [NUM_CH-1:0][CODE_W-1:0] s2Code;
  logic [ALPHA_W-1:0]            alphaQ, s1Alpha, s2Alpha;

  // alpha reduction: count thresholds crossed
  always_comb begin
    alphaQ = '0;
    for (int k = 1; k <= A_MAX; k++) begin
      if ((32'(inAlpha) * A_MAX + AIN_MAX / 2) >= 32'(k * AIN_MAX))
        alphaQ = alphaQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Alpha <= '0;
      s2Alpha <= '0;
    end else begin
      if (stb.ld1) s1Alpha <= alphaQ;
      if (stb.ld2) s2Alpha <= s1Alpha;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    exp_t        leadExp, s1Exp;
    logic        sat, s1Sat;
    fix_t        s1X;
    logic [5:0]  sh;
    fix_t        quo;
    logic        guardB, stickyB, roundUp;
    logic [CODE_W:0] sum;
    code_t       codeRnd;

    // stage 1: leading-one detect
    always_comb begin
      leadExp = '0;
      for (int b = LEAD_OFS + 1; b <= TOP_BIT; b++) begin
        if (inCh[c][b]) leadExp = EXP_W'(b - LEAD_OFS);
      end
      sat = inCh[c] >= FIX_W'(SAT_LIMIT);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1X   <= '0;
        s1Exp <= '0;
        s1Sat <= 1'b0;
      end else if (stb.ld1) begin
        s1X   <= inCh[c];
        s1Exp <= leadExp;
        s1Sat <= sat;
      end
    end

    // stage 2: shift and round to nearest even
    always_comb begin
      sh      = (s1Exp == '0) ? 6'(DEN_SHIFT) : 6'(s1Exp) + 6'(LEAD_OFS - MAN_W);
      quo     = s1X >> sh;
      guardB  = |((s1X >> (sh - 6'd1)) & FIX_W'(1));
      stickyB = |(s1X & ((FIX_W'(1) << (sh - 6'd1)) - FIX_W'(1)));
      roundUp = guardB & (stickyB | quo[0]);
      sum     = {1'b0, s1Exp, quo[MAN_W-1:0]} + (CODE_W+1)'(roundUp);
      codeRnd = (s1Sat || sum[CODE_W]) ? '1 : sum[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        s2Code[c] <= '0;
      else if (stb.ld2) s2Code[c] <= codeRnd;
    end

    // unpack path
    code_t       uCode;
    logic [5:0]  uSh;
    fix_t        uVal;
    always_comb begin
      uCode = unpkWord[c*CODE_W+ALPHA_W +: CODE_W];
      uSh   = (uCode[CODE_W-1:MAN_W] == '0) ? 6'(DEN_SHIFT)
            : 6'(uCode[CODE_W-1:MAN_W]) + 6'(LEAD_OFS - MAN_W);
      uVal  = FIX_W'({(uCode[CODE_W-1:MAN_W] != '0), uCode[MAN_W-1:0]}) << uSh;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           unpkCh[c] <= '0;
      else if (stb.ldUnpk) unpkCh[c] <= uVal;
    end
  end

  // stage 3: pack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packWord  <= '0;
      unpkAlpha <= '0;
    end else begin
      if (stb.ld3)    packWord  <= {s2Code, s2Alpha};
      if (stb.ldUnpk) unpkAlpha <= {A_REP{unpkWord[ALPHA_W-1:0]}};
    end
  end
endmodule

// File: rtl/hdr_pack_top.sv
module hdr_pack_top
  import hdr_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] inRed,
  input  logic [31:0] inGreen,
  input  logic [31:0] inBlue,
  input  logic [7:0]  inAlpha,
  output logic        outValid,
  output logic [31:0] outWord,
  input  logic        unpkValid,
  input  logic [31:0] unpkWord,
  output logic        unpkOutValid,
  output logic [31:0] unpkRed,
  output logic [31:0] unpkGreen,
  output logic [31:0] unpkBlue,
  output logic [7:0]  unpkAlpha
);
  strobe_t                      stb;
  logic [NUM_CH-1:0][FIX_W-1:0] inCh;
  logic [NUM_CH-1:0][FIX_W-1:0] unpkCh;

  assign inCh = {inRed, inGreen, inBlue};

  hdr_pack_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .unpkValid    (unpkValid),
    .stb          (stb),
    .outValid     (outValid),
    .unpkOutValid (unpkOutValid)
  );

  hdr_pack_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inCh      (inCh),
    .inAlpha   (inAlpha),
    .unpkWord  (unpkWord),
    .packWord  (outWord),
    .unpkCh    (unpkCh),
    .unpkAlpha (unpkAlpha)
  );

  assign unpkRed   = unpkCh[2];
  assign unpkGreen = unpkCh[1];
  assign unpkBlue  = unpkCh[0];
endmodule

// File: rtl/hdr_pack_chk.sv
module hdr_pack_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] inRed,
  input logic [7:0]  inAlpha,
  input logic        outValid,
  input logic [31:0] outWord,
  input logic        unpkValid,
  input logic        unpkOutValid,
  input logic [31:0] unpkRed
);
  logic [1:0] sinceRst;
  logic [2:0] vHist;
  logic       uHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      vHist    <= '0;
      uHist    <= 1'b0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      vHist <= {vHist[1:0], inValid};
      uHist <= unpkValid;
    end
  end

  // R7
  pack_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == vHist[2]));

  // R8
  unpack_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0) |-> (unpkOutValid == uHist));

  // R5
  red_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inRed >= 32'h000FF000) |-> ##3 (outWord[31:22] == 10'h3FF));

  // R3
  red_denormal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inRed < 32'h00001FE0) |-> ##3 (outWord[31:29] == 3'd0));

  // R6
  alpha_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inAlpha >= 8'd213) |-> ##3 (outWord[1:0] == 2'd3));

  // R8
  unpack_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    unpkOutValid |-> (unpkRed <= 32'h000FF000));
endmodule

bind hdr_pack_top hdr_pack_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inRed        (inRed),
  .inAlpha      (inAlpha),
  .outValid     (outValid),
  .outWord      (outWord),
  .unpkValid    (unpkValid),
  .unpkOutValid (unpkOutValid),
  .unpkRed      (unpkRed)
);

// File: tb/tb_hdr_pack_top.sv
`timescale 1ns/1ps
module tb_hdr_pack_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] inRed, inGreen, inBlue;
  logic [7:0]  inAlpha;
  logic        outValid;
  logic [31:0] outWord;
  logic        unpkValid;
  logic [31:0] unpkWord;
  logic        unpkOutValid;
  logic [31:0] unpkRed, unpkGreen, unpkBlue;
  logic [7:0]  unpkAlpha;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  hdr_pack_top dut (.*);

  function automatic logic [9:0] refCode(input logic [31:0] x);
    longint e, q, quo, rem;
    if (x >= 32'h000FF000) return 10'h3FF;
    e = 0;
    for (int k = 1; k <= 7; k++) if (longint'(x) >= (longint'(1) << (k + 12))) e = k;
    q   = (e == 0) ? 64 : (longint'(1) << (e + 5));
    quo = longint'(x) / q;
    rem = longint'(x) % q;
    if (rem * 2 > q || (rem * 2 == q && quo % 2 == 1)) quo++;
    return (e == 0) ? 10'(quo) : 10'((e - 1) * 128 + quo);
  endfunction

  function automatic logic [1:0] refAlpha(input logic [7:0] a);
    return 2'((int'(a) * 3 + 127) / 255);
  endfunction

  function automatic logic [31:0] refExpand(input logic [9:0] code);
    int e, m;
    e = int'(code >> 7);
    m = int'(code & 10'h7F);
    return (e == 0) ? 32'(m * 64) : 32'((128 + m) << (e + 5));
  endfunction

  function automatic logic [31:0] refWord(input logic [31:0] r, g, b, input logic [7:0] a);
    return {refCode(r), refCode(g), refCode(b), refAlpha(a)};
  endfunction

  logic        pV[3];
  logic [31:0] pW[3];
  string       pTag[3];
  logic        uPrevV;
  logic [31:0] uPrevW;

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] r, g, b, input logic [7:0] a,
                      input string tag, input logic uv, input logic [31:0] uw);
    @(negedge clk);
    check("R7", "outValid", 32'(outValid), 32'(pV[2]));
    if (pV[2]) check(pTag[2], "outWord", outWord, pW[2]);
    check("R8", "unpkOutValid", 32'(unpkOutValid), 32'(uPrevV));
    if (uPrevV) begin
      check("R8", "unpkRed",   unpkRed,   refExpand(uPrevW[31:22]));
      check("R8", "unpkGreen", unpkGreen, refExpand(uPrevW[21:12]));
      check("R8", "unpkBlue",  unpkBlue,  refExpand(uPrevW[11:2]));
      check("R8", "unpkAlpha", 32'(unpkAlpha), 32'(uPrevW[1:0]) * 85);
    end
    pV[2] = pV[1]; pW[2] = pW[1]; pTag[2] = pTag[1];
    pV[1] = pV[0]; pW[1] = pW[0]; pTag[1] = pTag[0];
    pV[0] = v; pW[0] = refWord(r, g, b, a); pTag[0] = tag;
    uPrevV = uv; uPrevW = uw;
    inValid = v; inRed = r; inGreen = g; inBlue = b; inAlpha = a;
    unpkValid = uv; unpkWord = uw;
  endtask

  task automatic pix(input logic [31:0] r, g, b, input logic [7:0] a, input string tag);
    step(1'b1, r, g, b, a, tag, 1'b0, 32'h0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(64'd20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 3; i++) begin pV[i] = 1'b0; pW[i] = '0; pTag[i] = "R7"; end
    uPrevV = 1'b0; uPrevW = '0;
    rstN = 1'b0; inValid = 1'b0; inRed = '0; inGreen = '0; inBlue = '0; inAlpha = '0;
    unpkValid = 1'b0; unpkWord = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "outValid", 32'(outValid), 32'h0);
    check("R9", "outWord", outWord, 32'h0);
    check("R9", "unpkOutValid", 32'(unpkOutValid), 32'h0);
    check("R9", "unpkRed", unpkRed, 32'h0);
    check("R9", "unpkAlpha", 32'(unpkAlpha), 32'h0);
    rstN = 1'b1;

    // R1 field placement with distinct channels
    pix(32'h00010000, 32'h00000040, 32'h00FFFFFF, 8'd255, "R1");
    check("R1", "refWord", refWord(32'h00010000, 32'h00000040, 32'h00FFFFFF, 8'd255),
          {10'h200, 10'h001, 10'h3FF, 2'd3});
    // R2 normal range
    pix(32'h00010000, 32'h00020000, 32'h00002000, 8'd0, "R2");
    pix(32'h00080000, 32'h00012345, 32'h0003C000, 8'd100, "R2");
    // R3 denormals
    pix(32'h00000040, 32'h00001FDF, 32'h00000000, 8'd0, "R3");
    pix(32'h0000003F, 32'h00000020, 32'h00000FFF, 8'd50, "R3");
    // R4 ties to even and carry into exponent
    pix(32'h00000060, 32'h000000A0, 32'h000000E0, 8'd0, "R4");
    pix(32'h00010100, 32'h00010300, 32'h00001FE0, 8'd0, "R4");
    pix(32'h000FE800, 32'h0000FFFF, 32'h0001FF80, 8'd0, "R4");
    // R5 saturation
    pix(32'h000FF000, 32'hFFFFFFFF, 32'h000FEFFF, 8'd0, "R5");
    pix(32'h00100000, 32'h000FF001, 32'h7FFFFFFF, 8'd0, "R5");
    // R6 alpha thresholds
    pix(32'h0, 32'h0, 32'h0, 8'd42, "R6");
    pix(32'h0, 32'h0, 32'h0, 8'd43, "R6");
    pix(32'h0, 32'h0, 32'h0, 8'd127, "R6");
    pix(32'h0, 32'h0, 32'h0, 8'd128, "R6");
    pix(32'h0, 32'h0, 32'h0, 8'd212, "R6");
    pix(32'h0, 32'h0, 32'h0, 8'd213, "R6");
    // R7 gap then resume
    step(1'b0, 32'h0, 32'h0, 32'h0, 8'd0, "R7", 1'b0, 32'h0);
    step(1'b0, 32'h0, 32'h0, 32'h0, 8'd0, "R7", 1'b0, 32'h0);
    pix(32'h00030000, 32'h00000800, 32'h00050000, 8'd200, "R7");
    // R8 directed unpack codes
    step(1'b0, 32'h0, 32'h0, 32'h0, 8'd0, "R8", 1'b1, {10'h3FF, 10'h001, 10'h080, 2'd2});
    step(1'b0, 32'h0, 32'h0, 32'h0, 8'd0, "R8", 1'b1, {10'h200, 10'h000, 10'h07F, 2'd1});

    // random mix: R1/R2/R3/R4 values spread across exponents
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rr, gg, bb;
      rr = $urandom >> (8 + $urandom % 24);
      gg = $urandom >> (8 + $urandom % 24);
      bb = $urandom >> (8 + $urandom % 24);
      step(($urandom % 4) != 0, rr, gg, bb, 8'($urandom), "R1/R2/R3/R4",
           ($urandom % 3) != 0, $urandom);
    end

    repeat (4) step(1'b0, 32'h0, 32'h0, 32'h0, 8'd0, "R7", 1'b0, 32'h0);
    summary();
    $finish;
  end
endmodule